// File: doc/BRIEF.md
# Masked Packed Narrowing Converter

This block narrows a vector of 32-bit integer lanes into 16-bit lanes in one clocked step. Each lane is converted by plain truncation, signed saturation or unsigned saturation, chosen by a mode input. The converted words are packed densely from the least-significant end of the result. The vector-length select sets how many lanes take part.

A per-lane write mask decides which lanes receive a converted word. For a register destination, a masked-off lane either keeps the prior destination word (merging) or is cleared (zeroing), and everything above the packed words is cleared. For a memory destination, only merging applies. The block then produces byte enables that cover exactly the written lanes, and it passes the prior contents through everywhere else.

An encoding field and the length select are checked. A bad value raises an illegal flag and suppresses the write. All outputs are registered, and a valid strobe follows each accepted input by one clock.

Top module: `lane_narrow`

## Requirements
- R1: With mode 0 (and also with the unused mode code 3), each output word is the low 16 bits of its source dword.
- R2: With mode 1, each dword is read as signed. Values above 32767 give 0x7FFF, values below -32768 give 0x8000, and all others give their low 16 bits.
- R3: With mode 2, each dword is read as unsigned. Values above 65535 give 0xFFFF, and all others give their low 16 bits.
- R4: The length select picks the active lane count: code 0 gives 4 lanes, code 1 gives 8 and code 2 gives 16. Result bits [16j+15:16j] come from source bits [32j+31:32j].
- R5: An active lane is written when mask_en is low or its mask bit is set. For a register destination (to_mem low), an unwritten active lane keeps its prior word when zeroing is low and becomes 0 when zeroing is high.
- R6: For a register destination, all result bits from 16 times the active lane count up to bit 511 are 0, and byte_en is all zero.
- R7: For a memory destination (to_mem high), zeroing has no effect. Unwritten lanes and all bits above the packed words carry the prior contents. byte_en bits 2j and 2j+1 are set exactly when lane j is written.
- R8: When spec is not 4'b1111, illegal is 1, result equals prior and byte_en is all zero.
- R9: Length-select code 3 is treated like R8: illegal is 1, result equals prior and byte_en is 0.
- R10: Mask bits at or above the active lane count have no effect on result or byte_en.
- R11: out_valid is high for exactly the cycle after each cycle with in_valid high. Outputs hold their values when in_valid is low. Reset clears out_valid, result, byte_en and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| src | input | 512 | Sixteen 32-bit source lanes |
| vl_sel | input | 2 | Vector length: 0=128, 1=256, 2=512, 3 illegal |
| mode | input | 2 | 0 truncate, 1 signed saturate, 2 unsigned saturate, 3 truncate |
| mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Mask honoured when high |
| zeroing | input | 1 | Clear unwritten register lanes when high |
| to_mem | input | 1 | Destination is memory when high |
| prior | input | 512 | Prior destination contents |
| spec | input | 4 | Encoding field, must be 4'b1111 |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Narrowed, masked result |
| byte_en | output | 32 | Byte write enables for a memory destination |
| illegal | output | 1 | Bad encoding seen |

## Verification
Masking and upper-bit clearing often act in the same cycle. A register-destination operation at the 128-bit length sets mask bits above lane 3 together with a mix of set and clear bits below. The result must show converted, merged or zeroed words in lanes 0 to 3, and zeros everywhere above, regardless of those high mask bits. Saturation and masking are also combined: a memory write with the mask set in scattered lanes is judged on both the clamped words and the exact byte-enable pattern.

// File: rtl/lane_narrow.sv
module lane_narrow #(
  parameter int LANES = 16,
  parameter int IW    = 32,
  parameter int OW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LANES*IW-1:0]   src,
  input  logic [1:0]            vl_sel,
  input  logic [1:0]            mode,
  input  logic [LANES-1:0]      mask,
  input  logic                  mask_en,
  input  logic                  zeroing,
  input  logic                  to_mem,
  input  logic [LANES*IW-1:0]   prior,
  input  logic [3:0]            spec,
  output logic                  out_valid,
  output logic [LANES*IW-1:0]   result,
  output logic [LANES*OW/8-1:0] byte_en,
  output logic                  illegal
);
  localparam int VW  = LANES * IW;
  localparam int NW  = LANES * OW;
  localparam int BPL = OW / 8;
  localparam int BW  = NW / 8;

  logic [LANES-1:0] act, take;
  logic [NW-1:0]    low_n;
  logic [VW-NW-1:0] hi_n;
  logic [BW-1:0]    be_n;
  logic             bad;

  assign bad  = (spec != 4'hF) | (vl_sel == 2'd3);
  assign hi_n = to_mem ? prior[VW-1:NW] : '0;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IW-1:0] d;
    logic [OW-1:0] cv, pw;
    assign d  = src[j*IW +: IW];
    assign pw = prior[j*OW +: OW];
    assign act[j]  = (vl_sel == 2'd2) | ((vl_sel == 2'd1) & (j < LANES/2))
                   | ((vl_sel == 2'd0) & (j < LANES/4));
    assign take[j] = act[j] & (~mask_en | mask[j]);
    always_comb begin
      case (mode)
        2'd1: begin
          if ((&d[IW-1:OW-1]) | ~(|d[IW-1:OW-1])) cv = d[OW-1:0];
          else cv = d[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
        end
        2'd2:    cv = (|d[IW-1:OW]) ? '1 : d[OW-1:0];
        default: cv = d[OW-1:0];
      endcase
    end
    assign low_n[j*OW +: OW] = take[j] ? cv :
                               (to_mem | (act[j] & ~zeroing)) ? pw : '0;
    assign be_n[j*BPL +: BPL] = {BPL{to_mem & take[j]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      byte_en   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal <= bad;
        result  <= bad ? prior : {hi_n, low_n};
        byte_en <= bad ? '0 : be_n;
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  bad_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && spec != 4'hF) |=> (illegal && byte_en == '0));
  // R6
  reg_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem) |=> (byte_en == '0));
  // R6
  reg_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem && vl_sel == 2'd0 && spec == 4'hF)
      |=> (result[VW-1:NW/4] == '0));
  // R7
  mem_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_mem) |=> (result[VW-1:NW] == $past(prior[VW-1:NW])));
endmodule

// File: tb/lane_narrow_bench.sv
module lane_narrow_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [511:0] src = '0, prior = '0;
  logic [1:0] vl_sel = 2'd2, mode = 2'd0;
  logic [15:0] mask = '0;
  logic mask_en = 1'b0, zeroing = 1'b0, to_mem = 1'b0;
  logic [3:0] spec = 4'hF;
  logic out_valid, illegal;
  logic [511:0] result;
  logic [31:0] byte_en;
  int checks = 0, fails = 0;
  logic [511:0] ex;

  always #2 clk = ~clk;

  lane_narrow u_lane_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .vl_sel(vl_sel),
    .mode(mode), .mask(mask), .mask_en(mask_en), .zeroing(zeroing),
    .to_mem(to_mem), .prior(prior), .spec(spec), .out_valid(out_valid),
    .result(result), .byte_en(byte_en), .illegal(illegal));

  // mode, source dword, expected word
  localparam logic [49:0] TBL [0:12] = '{
    {2'd0, 32'h12345678, 16'h5678}, {2'd0, 32'hFFFF8000, 16'h8000},
    {2'd1, 32'h00007FFF, 16'h7FFF}, {2'd1, 32'h00008000, 16'h7FFF},
    {2'd1, 32'hFFFF8000, 16'h8000}, {2'd1, 32'hFFFF7FFF, 16'h8000},
    {2'd1, 32'h80000000, 16'h8000}, {2'd1, 32'hFFFFFFFF, 16'hFFFF},
    {2'd2, 32'h0000FFFF, 16'hFFFF}, {2'd2, 32'h00010000, 16'hFFFF},
    {2'd2, 32'h00001234, 16'h1234}, {2'd2, 32'hFFFFFFFF, 16'hFFFF},
    {2'd3, 32'hABCD1234, 16'h1234}};

  task automatic chk(input string tag, input logic [511:0] a, input logic [511:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic go();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  function automatic logic [511:0] mk_prior();
    logic [511:0] p;
    for (int j = 0; j < 16; j++) p[j*16 +: 16] = 16'hC000 + 16'(j);
    p[511:256] = {8{32'hDEADBEEF}};
    return p;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", 512'(out_valid), '0);
    chk("R11 reset result", result, '0);
    chk("R11 reset byte_en", 512'(byte_en), '0);
    chk("R11 reset illegal", 512'(illegal), '0);
    rst_n = 1'b1;
    prior = mk_prior();

    // R1 R2 R3 table walk, 16 lanes, register, unmasked
    for (int t = 0; t < 13; t++) begin
      mode = TBL[t][49:48];
      src  = {16{TBL[t][47:16]}};
      go();
      ex = {256'd0, {16{TBL[t][15:0]}}};
      chk($sformatf("R1/R2/R3 row %0d", t), result, ex);
      chk("R6 register byte_en", 512'(byte_en), '0);
      chk("R11 valid pulse", 512'(out_valid), 512'd1);
    end
    @(negedge clk);
    chk("R11 valid drops", 512'(out_valid), '0);
    chk("R11 result holds", result, ex);

    // R4 lane mapping at each length
    mode = 2'd0;
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h00AB0000 + 32'(j + 1);
    for (int v = 0; v < 3; v++) begin
      vl_sel = 2'(v);
      go();
      ex = '0;
      for (int j = 0; j < (4 << v); j++) ex[j*16 +: 16] = 16'(j + 1);
      chk($sformatf("R4/R6 length code %0d", v), result, ex);
    end

    // R5 merge then zero, 16 lanes
    vl_sel = 2'd2; mask_en = 1'b1; mask = 16'h00F0; zeroing = 1'b0;
    go();
    ex = {256'd0, prior[255:0]};
    for (int j = 4; j < 8; j++) ex[j*16 +: 16] = 16'(j + 1);
    chk("R5 merge", result, ex);
    zeroing = 1'b1;
    go();
    ex = '0;
    for (int j = 4; j < 8; j++) ex[j*16 +: 16] = 16'(j + 1);
    chk("R5 zeroing", result, ex);

    // R10 R6 high mask bits ignored at 128-bit register length, merge
    vl_sel = 2'd0; mask = 16'hFFF5; zeroing = 1'b0; mode = 2'd1;
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h00012345;
    go();
    ex = '0;
    ex[15:0] = 16'h7FFF; ex[31:16] = 16'hC001;
    ex[47:32] = 16'h7FFF; ex[63:48] = 16'hC003;
    chk("R10 high mask bits register", result, ex);

    // R7 R10 memory, 256-bit, zeroing ignored, mask above 8 ignored
    vl_sel = 2'd1; mask = 16'hFFA5; zeroing = 1'b1; to_mem = 1'b1; mode = 2'd2;
    go();
    ex = prior;
    ex[15:0] = 16'hFFFF; ex[47:32] = 16'hFFFF;
    ex[95:80] = 16'hFFFF; ex[127:112] = 16'hFFFF;
    chk("R7 memory result", result, ex);
    chk("R7/R10 memory byte_en", 512'(byte_en), 512'h0000CC33);

    // R7 memory unmasked full length
    vl_sel = 2'd2; mask_en = 1'b0; mode = 2'd0;
    go();
    ex = {prior[511:256], {16{16'h2345}}};
    chk("R7 memory full", result, ex);
    chk("R7 memory full byte_en", 512'(byte_en), 512'hFFFFFFFF);

    // R8 bad encoding field
    spec = 4'b1110;
    go();
    chk("R8 illegal flag", 512'(illegal), 512'd1);
    chk("R8 result is prior", result, prior);
    chk("R8 byte_en off", 512'(byte_en), '0);

    // R9 bad length code
    spec = 4'hF; vl_sel = 2'd3; to_mem = 1'b0;
    go();
    chk("R9 illegal flag", 512'(illegal), 512'd1);
    chk("R9 result is prior", result, prior);
    vl_sel = 2'd2;
    go();
    chk("R9 legal clears flag", 512'(illegal), '0);

    // R11 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears result", result, '0);
    chk("R11 reset clears valid", 512'(out_valid), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule